// File: doc/BRIEF.md
# Lockable Device Translation Buffer

This block is a fully associative translation cache for the memory management unit that sits in front of a device master. Each of its entries maps one device virtual page to one physical page, and each entry picks its own page size from four choices: 4 KiB, 64 KiB, 1 MiB or 16 MiB. A lookup is combinational. The lowest-index entry that covers the address wins and returns the translated physical address. A lookup that finds no entry either asks an external table walker to run or raises a held fault to the host, depending on a control bit.

A small host register file programs the cache. A lock register holds two indices. The base is the number of preserved entries at the bottom of the array, and the victim is the entry that the next load, flush or readback acts on. After each load the victim steps upward and wraps back to the base, so preserved entries are never overwritten by round-robin refill. Software preserves an entry by pointing the victim at the base, loading, and then raising the base by one.

Register map (word index on `reg_addr_i`):
- 0 = control, bit 0 enables walking.
- 1 = lock, victim in bits [15:0] and base in bits [31:16].
- 2 = staged tag.
- 3 = staged physical page.
- 4 = command, write-only, one bit per command:
  - bit 0: load.
  - bit 1: flush the entry at the victim.
  - bit 2: flush all entries.
  - bit 3: clear the fault.
- 5 = read-back tag.
- 6 = read-back physical page.
- 7 = faulting address.

Tag word layout:
- Bits [1:0] hold the page size: 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB, 3 = 16 MiB.
- Bit 2 reads back the valid flag.
- The upper bits hold the virtual page.

Top module: `io_tlb`

## Requirements
- R1: After reset every entry is invalid, base and victim are 0, walking is disabled and `irq_o` is low.
- R2: A load command writes the staged tag and physical page into the entry at the victim and marks it valid. Registers 5 and 6 return the entry at the victim, with the valid flag in tag bit 2.
- R3: A load advances the victim by one. When the victim was at entry count minus one, it moves to the current base instead.
- R4: Entries below the base are never overwritten by round-robin loads and stay translatable.
- R5: A per-entry flush clears the valid flag of the entry at the victim, leaves its stored tag readable, and does not move the victim.
- R6: A global flush invalidates every entry and sets base and victim to 0.
- R7: An entry covers an address when the address lies in [start, start + size), where size comes from tag code 0 = 4 KiB, 1 = 64 KiB, 2 = 1 MiB or 3 = 16 MiB.
- R8: On a hit, `lkp_pa_o` takes the entry's physical page above the page offset and the request's offset bits below it.
- R9: When several valid entries cover the address, the lowest-index entry supplies the translation.
- R10: A missed lookup with walking enabled drives `walk_req_o` high in the same cycle and raises no fault.
- R11: A missed lookup with walking disabled captures its address in register 7 and sets `irq_o`. `irq_o` and the captured address hold, even across later misses, until a write of command bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Host register index |
| reg_wdata_i | input | 32 | Host write data |
| reg_rdata_o | output | 32 | Host read data for `reg_addr_i`, combinational |
| lkp_valid_i | input | 1 | Lookup request valid |
| lkp_va_i | input | VA_W | Lookup device virtual address |
| lkp_hit_o | output | 1 | Lookup hit |
| lkp_pa_o | output | PA_W | Translated physical address |
| walk_req_o | output | 1 | Miss with walking enabled, request a table walk |
| irq_o | output | 1 | Held miss fault with walking disabled |

## Verification
The assertions check several rules on every cycle:
- the hit is always the lowest-index covering entry;
- a global flush always returns base and victim to zero;
- every load moves the victim either one step up or back to the base;
- a pending fault keeps both `irq_o` and the captured address until the clear command, and a walk request never coincides with a new fault.

Other behaviours can only be shown by the bench's scenarios, because they depend on the stored contents:
- the translated address for each page size;
- the right end of each coverage window;
- preserved entries surviving a full round-robin wrap;
- a per-entry flush hiding exactly one mapping.

// File: rtl/io_tlb_pkg.sv
package io_tlb_pkg;
  localparam int REG_W = 32;

  localparam logic [2:0] RA_CTRL  = 3'd0;
  localparam logic [2:0] RA_LOCK  = 3'd1;
  localparam logic [2:0] RA_STAG  = 3'd2;
  localparam logic [2:0] RA_SPA   = 3'd3;
  localparam logic [2:0] RA_CMD   = 3'd4;
  localparam logic [2:0] RA_RTAG  = 3'd5;
  localparam logic [2:0] RA_RPA   = 3'd6;
  localparam logic [2:0] RA_FAULT = 3'd7;

  localparam int LOCK_BASE_LSB = 16;
  localparam int TAG_VALID_BIT = 2;

  // size code 0..3 -> 4K, 64K, 1M, 16M
  function automatic int unsigned pg_shift(input logic [1:0] code);
    return 32'd12 + 32'd4 * 32'(code);
  endfunction
endpackage

// File: rtl/tlb_entry_array.sv
module tlb_entry_array
  import io_tlb_pkg::*;
#(
  parameter int N     = 32,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          idx_i,
  input  logic [VA_W-1:0]           wr_tag_i,
  input  logic [PA_W-1:0]           wr_pa_i,
  input  logic                      inv_one_i,
  input  logic                      inv_all_i,
  input  logic [VA_W-1:0]           lkp_va_i,
  output logic [N-1:0]              match_o,
  output logic [N-1:0]              valid_o,
  output logic [N-1:0][VA_W-1:0]    tag_o,
  output logic [N-1:0][PA_W-1:0]    pa_o
);
  for (genvar i = 0; i < N; i++) begin : g_ent
    logic [VA_W-1:0] off_mask;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_o[i] <= 1'b0;
        tag_o[i]   <= '0;
        pa_o[i]    <= '0;
      end else if (inv_all_i) begin
        valid_o[i] <= 1'b0;
      end else if (wr_en_i && idx_i == IDX_W'(i)) begin
        valid_o[i] <= 1'b1;
        tag_o[i]   <= wr_tag_i;
        pa_o[i]    <= wr_pa_i;
      end else if (inv_one_i && idx_i == IDX_W'(i)) begin
        valid_o[i] <= 1'b0;
      end
    end

    assign off_mask   = (VA_W'(1) << pg_shift(tag_o[i][1:0])) - VA_W'(1);
    assign match_o[i] = valid_o[i] && (((lkp_va_i ^ tag_o[i]) & ~off_mask) == '0);
  end
endmodule

// File: rtl/tlb_lock_ctrl.sv
module tlb_lock_ctrl #(
  parameter int N     = 32,
  parameter int CNT_W = $clog2(N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lock_we_i,
  input  logic [CNT_W-1:0] base_wr_i,
  input  logic [CNT_W-1:0] vic_wr_i,
  input  logic             load_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] base_o,
  output logic [CNT_W-1:0] vic_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= '0;
      vic_o  <= '0;
    end else if (clr_i) begin
      base_o <= '0;
      vic_o  <= '0;
    end else if (lock_we_i) begin
      base_o <= base_wr_i;
      vic_o  <= vic_wr_i;
    end else if (load_i) begin
      vic_o <= (vic_o == LAST) ? base_o : vic_o + 1'b1;
    end
  end

  // R6
  flush_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (base_o == '0 && vic_o == '0));
  // R3
  victim_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && !lock_we_i && vic_o == LAST) |=> vic_o == $past(base_o));
  // R3
  victim_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clr_i && !lock_we_i && vic_o < LAST) |=> vic_o == $past(vic_o) + 1'b1);
endmodule

// File: rtl/tlb_prio_enc.sv
module tlb_prio_enc #(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
    any_o = |req_i;
  end
endmodule

// File: rtl/io_tlb.sv
module io_tlb
  import io_tlb_pkg::*;
#(
  parameter int NUM_ENTRIES = 32,
  parameter int VA_W        = 32,
  parameter int PA_W        = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [2:0]       reg_addr_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             lkp_valid_i,
  input  logic [VA_W-1:0]  lkp_va_i,
  output logic             lkp_hit_o,
  output logic [PA_W-1:0]  lkp_pa_o,
  output logic             walk_req_o,
  output logic             irq_o
);
  localparam int IDX_W = $clog2(NUM_ENTRIES);
  localparam int CNT_W = $clog2(NUM_ENTRIES + 1);

  logic                            walk_en_q;
  logic [VA_W-1:0]                 stag_q;
  logic [PA_W-1:0]                 spa_q;
  logic [VA_W-1:0]                 fault_va_q;
  logic                            fault_q;
  logic [CNT_W-1:0]                base, vic;
  logic                            vic_ok;
  logic [IDX_W-1:0]                vic_idx;
  logic                            cmd_we, lock_we;
  logic                            do_load, do_inv1, do_inv_all, do_fclr;
  logic [NUM_ENTRIES-1:0]          match, valid;
  logic [NUM_ENTRIES-1:0][VA_W-1:0] tags;
  logic [NUM_ENTRIES-1:0][PA_W-1:0] pas;
  logic                            any_match;
  logic [IDX_W-1:0]                hit_idx;
  logic [VA_W-1:0]                 hit_mask;
  logic                            miss;

  assign cmd_we     = reg_we_i && reg_addr_i == RA_CMD;
  assign lock_we    = reg_we_i && reg_addr_i == RA_LOCK;
  assign vic_ok     = vic < CNT_W'(NUM_ENTRIES);
  assign vic_idx    = IDX_W'(vic);
  assign do_inv_all = cmd_we && reg_wdata_i[2];
  assign do_load    = cmd_we && reg_wdata_i[0] && vic_ok && !do_inv_all;
  assign do_inv1    = cmd_we && reg_wdata_i[1] && vic_ok;
  assign do_fclr    = cmd_we && reg_wdata_i[3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      walk_en_q <= 1'b0;
      stag_q    <= '0;
      spa_q     <= '0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        RA_CTRL: walk_en_q <= reg_wdata_i[0];
        RA_STAG: stag_q    <= reg_wdata_i[VA_W-1:0];
        RA_SPA:  spa_q     <= reg_wdata_i[PA_W-1:0];
        default: ;
      endcase
    end
  end

  tlb_lock_ctrl #(.N(NUM_ENTRIES), .CNT_W(CNT_W)) u_lock (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lock_we_i (lock_we),
    .base_wr_i (reg_wdata_i[LOCK_BASE_LSB +: CNT_W]),
    .vic_wr_i  (reg_wdata_i[CNT_W-1:0]),
    .load_i    (do_load),
    .clr_i     (do_inv_all),
    .base_o    (base),
    .vic_o     (vic)
  );

  tlb_entry_array #(.N(NUM_ENTRIES), .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W)) u_arr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (do_load),
    .idx_i     (vic_idx),
    .wr_tag_i  (stag_q),
    .wr_pa_i   (spa_q),
    .inv_one_i (do_inv1),
    .inv_all_i (do_inv_all),
    .lkp_va_i  (lkp_va_i),
    .match_o   (match),
    .valid_o   (valid),
    .tag_o     (tags),
    .pa_o      (pas)
  );

  tlb_prio_enc #(.N(NUM_ENTRIES), .IDX_W(IDX_W)) u_enc (
    .req_i (match),
    .any_o (any_match),
    .idx_o (hit_idx)
  );

  assign hit_mask   = (VA_W'(1) << pg_shift(tags[hit_idx][1:0])) - VA_W'(1);
  assign lkp_hit_o  = lkp_valid_i && any_match;
  assign lkp_pa_o   = (pas[hit_idx] & ~PA_W'(hit_mask)) | PA_W'(lkp_va_i & hit_mask);
  assign miss       = lkp_valid_i && !any_match;
  assign walk_req_o = miss && walk_en_q;

  // first fault is held until cleared
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q    <= 1'b0;
      fault_va_q <= '0;
    end else if (do_fclr) begin
      fault_q <= 1'b0;
    end else if (miss && !walk_en_q && !fault_q) begin
      fault_q    <= 1'b1;
      fault_va_q <= lkp_va_i;
    end
  end
  assign irq_o = fault_q;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      RA_CTRL: reg_rdata_o[0] = walk_en_q;
      RA_LOCK: begin
        reg_rdata_o[CNT_W-1:0]             = vic;
        reg_rdata_o[LOCK_BASE_LSB +: CNT_W] = base;
      end
      RA_STAG: reg_rdata_o[VA_W-1:0] = stag_q;
      RA_SPA:  reg_rdata_o[PA_W-1:0] = spa_q;
      RA_RTAG: if (vic_ok) begin
        reg_rdata_o[VA_W-1:0]      = tags[vic_idx];
        reg_rdata_o[TAG_VALID_BIT] = valid[vic_idx];
      end
      RA_RPA:  if (vic_ok) reg_rdata_o[PA_W-1:0] = pas[vic_idx];
      RA_FAULT: reg_rdata_o[VA_W-1:0] = fault_va_q;
      default: ;
    endcase
  end

  // R9
  lowest_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_hit_o |-> (match[hit_idx] &&
      ((match & ((NUM_ENTRIES'(1) << hit_idx) - NUM_ENTRIES'(1))) == '0)));
  // R11
  irq_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !do_fclr) |=> irq_o);
  // R11
  fault_va_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> $stable(fault_va_q));
  // R10
  walk_no_fault_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (walk_req_o && !irq_o) |=> !irq_o);
endmodule

// File: tb/io_tlb_bench.sv
module io_tlb_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lv = 1'b0;
  logic [31:0] va = '0;
  logic        hit;
  logic [31:0] pa;
  logic        walk;
  logic        irq;
  int          n_tests = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  io_tlb #(.NUM_ENTRIES(NE), .VA_W(32), .PA_W(32)) u_io_tlb (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lkp_valid_i(lv),
    .lkp_va_i(va), .lkp_hit_o(hit), .lkp_pa_o(pa),
    .walk_req_o(walk), .irq_o(irq)
  );

  // {hit, va, pa}; walking enabled while these run
  localparam logic [64:0] VECS [0:7] = '{
    {1'b1, 32'h10AB_CDEF, 32'h80AB_CDEF},  // R7 16M
    {1'b0, 32'h1100_0000, 32'h0},          // R7 16M end
    {1'b1, 32'h2000_0ABC, 32'h0012_3ABC},  // R9 entry1 over entry4
    {1'b1, 32'h2000_1000, 32'h0770_1000},  // R7 4K end, 1M hit
    {1'b1, 32'h3000_FFFF, 32'h4567_FFFF},  // R8 64K
    {1'b0, 32'h3001_0000, 32'h0},          // R7 64K end
    {1'b1, 32'h400F_1234, 32'h0ABF_1234},  // R8 1M
    {1'b0, 32'h0FFF_FFFF, 32'h0}           // R7 below start
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic lk(input logic [31:0] a, output logic h, output logic [31:0] p, output logic w);
    @(negedge clk);
    lv = 1'b1; va = a;
    #1 h = hit; p = pa; w = walk;
    @(negedge clk);
    lv = 1'b0;
  endtask

  task automatic load(input logic [31:0] t, input logic [31:0] p);
    wr(3'd2, t);
    wr(3'd3, p);
    wr(3'd4, 32'h1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, p;
    logic h, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd1, d); chk("R1 lock", d, 32'h0);
    rd(3'd0, d); chk("R1 ctrl", d, 32'h0);
    rd(3'd5, d); chk("R1 entry invalid", d, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // preserved entry 0
    load(32'h1000_0003, 32'h8000_0000);
    rd(3'd1, d); chk("R3 step", d, 32'h0000_0001);
    wr(3'd1, 32'h0001_0001);
    load(32'h2000_0000, 32'h0012_3000);
    load(32'h3000_0001, 32'h4567_0000);
    load(32'h4000_0002, 32'h0AB0_0000);
    load(32'h2000_0002, 32'h0770_0000);
    rd(3'd1, d); chk("R3 victim 5", d, 32'h0001_0005);

    wr(3'd0, 32'h1);
    foreach (VECS[i]) begin
      lk(VECS[i][63:32], h, p, w);
      chk($sformatf("R7 hit v%0d", i), 32'(h), 32'(VECS[i][64]));
      if (VECS[i][64]) chk($sformatf("R8 pa v%0d", i), p, VECS[i][31:0]);
      chk($sformatf("R10 walk v%0d", i), 32'(w), 32'(!VECS[i][64]));
    end
    chk("R10 no irq", 32'(irq), 32'h0);

    load(32'h6000_0000, 32'h0000_1000);
    load(32'h6100_0000, 32'h0000_2000);
    load(32'h6200_0000, 32'h0000_3000);
    rd(3'd1, d); chk("R3 wrap to base", d, 32'h0001_0001);
    load(32'h5000_0000, 32'h0011_1000);
    rd(3'd1, d); chk("R3 after wrap", d, 32'h0001_0002);
    lk(32'h1000_0000, h, p, w); chk("R4 preserved", p, 32'h8000_0000);
    chk("R4 preserved hit", 32'(h), 32'h1);
    lk(32'h2000_0ABC, h, p, w); chk("R9 replaced entry", p, 32'h0770_0ABC);
    lk(32'h5000_0123, h, p, w); chk("R2 new entry", p, 32'h0011_1123);

    wr(3'd1, 32'h0001_0002);
    rd(3'd5, d); chk("R2 readback tag", d, 32'h3000_0005);
    rd(3'd6, d); chk("R2 readback pa", d, 32'h4567_0000);

    wr(3'd4, 32'h2);
    rd(3'd5, d); chk("R5 tag invalid", d, 32'h3000_0001);
    rd(3'd1, d); chk("R5 victim kept", d, 32'h0001_0002);
    lk(32'h3000_0010, h, p, w); chk("R5 lookup miss", 32'(h), 32'h0);

    wr(3'd0, 32'h0);
    lk(32'h7000_0000, h, p, w); chk("R11 no walk", 32'(w), 32'h0);
    chk("R11 irq set", 32'(irq), 32'h1);
    rd(3'd7, d); chk("R11 fault va", d, 32'h7000_0000);
    lk(32'h7100_0000, h, p, w);
    rd(3'd7, d); chk("R11 first kept", d, 32'h7000_0000);
    chk("R11 irq held", 32'(irq), 32'h1);
    wr(3'd4, 32'h8);
    chk("R11 irq cleared", 32'(irq), 32'h0);
    lk(32'h1000_0004, h, p, w);
    chk("R11 hit no fault", 32'(irq), 32'h0);

    wr(3'd4, 32'h4);
    rd(3'd1, d); chk("R6 lock zero", d, 32'h0);
    rd(3'd5, d); chk("R6 entry0 invalid", d, 32'h1000_0003);
    lk(32'h1000_0000, h, p, w); chk("R6 miss", 32'(h), 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule